// File: doc/BRIEF.md
# Odd-Parity SECDED Codec

This block protects one byte with a 13-bit single-error-correct, double-error-detect code word built on odd parity. The encoder spreads the data bits over the code positions that are not powers of two. It fills positions 1, 2, 4 and 8 with Hamming check bits. Position 0 holds one more bit, which makes the parity of the whole word odd.

The checker takes a received 13-bit word and computes the failed-check pattern (the syndrome) and the overall parity state. It then returns the byte, repaired if one position was hit. It also returns a status code that separates a clean word, a repaired single error and an uncorrectable word.

Both paths are registered. A word or byte presented with its valid strobe on one rising edge gives its result, with a valid flag, right after that edge. The two paths are independent, so an encode and a decode may be issued in the same cycle.

Top module: `secded_codec`

## Requirements
- R1: Code word bit i carries position i. The data byte goes most significant bit first into positions 3, 5, 6, 7, 9, 10, 11 and 12.
- R2: For each check index c (0 to 3), the bit at position 2^c is set so that all positions whose index has bit c set, that check bit included, hold an odd number of ones.
- R3: Position 0 is set so that the whole 13-bit word holds an odd number of ones. Byte 0x6B encodes to 13'h1A65.
- R4: The encoded word and encOutValid appear one clock after encInValid is sampled high. With encInValid low, encOutValid is 0 the next cycle and encWord keeps its value even if encData changes.
- R5: A word with no failed check and odd overall parity returns its data bits unchanged, with decStatus 0 (clean).
- R6: A word with exactly one flipped bit at positions 1 to 12 returns the original byte with decStatus 1 (corrected).
- R7: A word whose only flipped bit is position 0 returns the original byte with decStatus 1.
- R8: A word with exactly two flipped bits gives decStatus 2 (uncorrectable). decData then holds the received data bits without any repair.
- R9: A syndrome of 13, 14 or 15 together with wrong overall parity gives decStatus 2. decData then holds the received data bits. The value 3 never appears on decStatus.
- R10: decData, decStatus and decOutValid appear one clock after decInValid is sampled high. With decInValid low, decOutValid is 0 the next cycle and decData and decStatus keep their values.
- R11: While rstN is low, encOutValid, decOutValid, encWord, decData and decStatus are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| encInValid | input | 1 | Load encData into the encoder this cycle |
| encData | input | 8 | Byte to encode |
| decInValid | input | 1 | Load decWord into the checker this cycle |
| decWord | input | 13 | Received code word, bit i is position i |
| encOutValid | output | 1 | encWord updated on the last edge |
| encWord | output | 13 | Encoded code word |
| decOutValid | output | 1 | decData and decStatus updated on the last edge |
| decData | output | 8 | Recovered byte |
| decStatus | output | 2 | 0 clean, 1 corrected, 2 uncorrectable |

## Verification
Each result is due exactly one rising edge after its strobe is sampled. The bench drives a stimulus at a falling edge and samples at the next falling edge, so exactly one register stage lies between the drive and the sample. To check the hold behaviour, it waits one more falling edge with the strobe low, changes the inputs, and confirms that the flags have dropped and the values are unchanged. Every byte value is encoded. For every byte, the bench decodes the clean word, all 13 single flips and all 78 flip pairs. It also checks triple flips chosen to give syndromes 13 to 15.

// File: rtl/secded_pkg.sv
package secded_pkg;

  typedef enum logic [1:0] {
    ST_CLEAN = 2'd0,
    ST_FIXED = 2'd1,
    ST_FATAL = 2'd2
  } decStatus_t;

  typedef struct packed {
    logic encLoad;
    logic decLoad;
  } strobes_t;

  // smallest r with 2^r >= dataW + r + 1
  function automatic int checkCount(input int dataW);
    int r;
    r = 0;
    while ((1 << r) < (dataW + r + 1)) r++;
    return r;
  endfunction

  function automatic bit isPow2(input int p);
    return (p > 0) && ((p & (p - 1)) == 0);
  endfunction

endpackage

// File: rtl/secded_ctrl.sv
module secded_ctrl
  import secded_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     encInValid,
  input  logic     decInValid,
  output strobes_t strobes,
  output logic     encOutValid,
  output logic     decOutValid
);

  always_comb begin
    strobes.encLoad = encInValid;
    strobes.decLoad = decInValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      encOutValid <= 1'b0;
      decOutValid <= 1'b0;
    end else begin
      encOutValid <= encInValid;
      decOutValid <= decInValid;
    end
  end

endmodule

// File: rtl/secded_datapath.sv
module secded_datapath
  import secded_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CHK_W  = 4,
  parameter int CODE_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic [DATA_W-1:0] encData,
  input  logic [CODE_W-1:0] decWord,
  output logic [CODE_W-1:0] encWord,
  output logic [DATA_W-1:0] decData,
  output logic [1:0]        decStatus
);

  // position of the j-th data bit (j = 0 is the most significant)
  function automatic int dataPos(input int j);
    int cnt;
    int pos;
    cnt = 0;
    pos = 0;
    for (int p = 1; p < CODE_W; p++) begin
      if (!isPow2(p)) begin
        if (cnt == j) pos = p;
        cnt++;
      end
    end
    return pos;
  endfunction

  function automatic logic [CODE_W-1:0] coverMask(input int c);
    logic [CODE_W-1:0] m;
    m = '0;
    for (int p = 1; p < CODE_W; p++) m[p] = ((p >> c) & 1) == 1;
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] extractData(input logic [CODE_W-1:0] w);
    logic [DATA_W-1:0] d;
    for (int j = 0; j < DATA_W; j++) d[DATA_W-1-j] = w[dataPos(j)];
    return d;
  endfunction

  function automatic logic [CODE_W-1:0] buildWord(input logic [DATA_W-1:0] d);
    logic [CODE_W-1:0] w;
    w = '0;
    for (int j = 0; j < DATA_W; j++) w[dataPos(j)] = d[DATA_W-1-j];
    for (int c = 0; c < CHK_W; c++) w[1 << c] = ~^(w & coverMask(c));
    w[0] = ~^w[CODE_W-1:1];
    return w;
  endfunction

  // encoder
  logic [CODE_W-1:0] encNext;

  always_comb encNext = buildWord(encData);

  // checker
  logic [CHK_W-1:0]  syndrome;
  logic              parityBad;
  logic              synZero;
  logic              synInRange;
  logic              flipEn;
  logic [CODE_W-1:0] flipMask;
  logic [CODE_W-1:0] repaired;
  decStatus_t        statusNext;

  always_comb begin
    for (int c = 0; c < CHK_W; c++) syndrome[c] = ~^(decWord & coverMask(c));
    parityBad  = ~^decWord;
    synZero    = (syndrome == '0);
    synInRange = int'(syndrome) < CODE_W;

    flipEn = 1'b0;
    if (synZero) begin
      statusNext = parityBad ? ST_FIXED : ST_CLEAN;
    end else if (parityBad && synInRange) begin
      statusNext = ST_FIXED;
      flipEn     = 1'b1;
    end else begin
      statusNext = ST_FATAL;
    end

    for (int p = 0; p < CODE_W; p++) flipMask[p] = flipEn && (int'(syndrome) == p);
    repaired = decWord ^ flipMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      encWord   <= '0;
      decData   <= '0;
      decStatus <= ST_CLEAN;
    end else begin
      if (strobes.encLoad) encWord <= encNext;
      if (strobes.decLoad) begin
        decData   <= extractData(repaired);
        decStatus <= statusNext;
      end
    end
  end

endmodule

// File: rtl/secded_codec.sv
module secded_codec
  import secded_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CHK_W  = checkCount(DATA_W),
  localparam int CODE_W = DATA_W + CHK_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              encInValid,
  input  logic [DATA_W-1:0] encData,
  input  logic              decInValid,
  input  logic [CODE_W-1:0] decWord,
  output logic              encOutValid,
  output logic [CODE_W-1:0] encWord,
  output logic              decOutValid,
  output logic [DATA_W-1:0] decData,
  output logic [1:0]        decStatus
);

  strobes_t strobes;

  secded_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .encInValid  (encInValid),
    .decInValid  (decInValid),
    .strobes     (strobes),
    .encOutValid (encOutValid),
    .decOutValid (decOutValid)
  );

  secded_datapath #(
    .DATA_W (DATA_W),
    .CHK_W  (CHK_W),
    .CODE_W (CODE_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .encData   (encData),
    .decWord   (decWord),
    .encWord   (encWord),
    .decData   (decData),
    .decStatus (decStatus)
  );

endmodule

// File: rtl/secded_codec_chk.sv
module secded_codec_chk #(
  parameter int DATA_W = 8,
  parameter int CODE_W = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic              encInValid,
  input logic [DATA_W-1:0] encData,
  input logic              decInValid,
  input logic [CODE_W-1:0] decWord,
  input logic              encOutValid,
  input logic [CODE_W-1:0] encWord,
  input logic              decOutValid,
  input logic [DATA_W-1:0] decData,
  input logic [1:0]        decStatus
);

  a_r4_enc_latency: assert property (@(posedge clk) disable iff (!rstN)
    encInValid |=> encOutValid);

  a_r4_enc_hold: assert property (@(posedge clk) disable iff (!rstN)
    !encInValid |=> (!encOutValid && $stable(encWord)));

  a_r3_odd_word: assert property (@(posedge clk) disable iff (!rstN)
    encOutValid |-> (^encWord));

  a_r10_dec_latency: assert property (@(posedge clk) disable iff (!rstN)
    decInValid |=> decOutValid);

  a_r10_dec_hold: assert property (@(posedge clk) disable iff (!rstN)
    !decInValid |=> (!decOutValid && $stable(decData) && $stable(decStatus)));

  a_r9_status_legal: assert property (@(posedge clk) disable iff (!rstN)
    decStatus != 2'd3);

  // R11: reset clears the valid flags
  a_r11_reset_clears: assert property (@(posedge clk)
    !rstN |=> (!encOutValid && !decOutValid));

  logic unusedIn;
  always_comb unusedIn = ^{encData, decWord, decData};

endmodule

bind secded_codec secded_codec_chk #(
  .DATA_W (DATA_W),
  .CODE_W (CODE_W)
) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .encInValid  (encInValid),
  .encData     (encData),
  .decInValid  (decInValid),
  .decWord     (decWord),
  .encOutValid (encOutValid),
  .encWord     (encWord),
  .decOutValid (decOutValid),
  .decData     (decData),
  .decStatus   (decStatus)
);

// File: tb/secded_codec_tb_top.sv
`timescale 1ns/1ps
module secded_codec_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        encInValid = 1'b0;
  logic [7:0]  encData = '0;
  logic        decInValid = 1'b0;
  logic [12:0] decWord = '0;
  logic        encOutValid;
  logic [12:0] encWord;
  logic        decOutValid;
  logic [7:0]  decData;
  logic [1:0]  decStatus;

  int nCompared = 0;
  int nMismatched = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  secded_codec dut_i (
    .clk(clk), .rstN(rstN),
    .encInValid(encInValid), .encData(encData),
    .decInValid(decInValid), .decWord(decWord),
    .encOutValid(encOutValid), .encWord(encWord),
    .decOutValid(decOutValid), .decData(decData), .decStatus(decStatus)
  );

  function automatic bit isCheckPos(input int p);
    return (p & (p - 1)) == 0;
  endfunction

  function automatic logic [12:0] refEncode(input logic [7:0] d);
    logic [12:0] w;
    int j;
    int n;
    w = '0;
    j = 0;
    for (int p = 1; p < 13; p++) begin
      if (!isCheckPos(p)) begin
        w[p] = d[7-j];
        j++;
      end
    end
    for (int c = 0; c < 4; c++) begin
      n = 0;
      for (int p = 1; p < 13; p++) if (((p >> c) & 1) == 1 && w[p]) n++;
      w[1 << c] = (n % 2 == 0);
    end
    w[0] = ($countones(w[12:1]) % 2 == 0);
    return w;
  endfunction

  function automatic logic [7:0] refExtract(input logic [12:0] w);
    logic [7:0] d;
    int j;
    j = 0;
    d = '0;
    for (int p = 1; p < 13; p++) begin
      if (!isCheckPos(p)) begin
        d[7-j] = w[p];
        j++;
      end
    end
    return d;
  endfunction

  task automatic checkEq(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    nCompared++;
    if (act !== exp) begin
      nMismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic doEncode(input logic [7:0] d, input logic [12:0] expW, input string req);
    @(negedge clk);
    encInValid = 1'b1;
    encData = d;
    @(negedge clk);
    encInValid = 1'b0;
    checkEq(req, "encOutValid", 32'(encOutValid), 32'd1);
    checkEq(req, "encWord", 32'(encWord), 32'(expW));
  endtask

  task automatic doDecode(input logic [12:0] w, input logic [7:0] expD,
                          input logic [1:0] expS, input string req);
    @(negedge clk);
    decInValid = 1'b1;
    decWord = w;
    @(negedge clk);
    decInValid = 1'b0;
    checkEq(req, "decOutValid", 32'(decOutValid), 32'd1);
    checkEq(req, "decData", 32'(decData), 32'(expD));
    checkEq(req, "decStatus", 32'(decStatus), 32'(expS));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nCompared++;
      nMismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
      $finish;
    end
  end

  initial begin : main
    logic [12:0] w;
    logic [12:0] bad;
    int n;

    // R11: reset state
    repeat (3) @(negedge clk);
    checkEq("R11", "encOutValid", 32'(encOutValid), 32'd0);
    checkEq("R11", "decOutValid", 32'(decOutValid), 32'd0);
    checkEq("R11", "encWord", 32'(encWord), 32'd0);
    checkEq("R11", "decData", 32'(decData), 32'd0);
    checkEq("R11", "decStatus", 32'(decStatus), 32'd0);
    rstN = 1'b1;

    // R3: known vector
    doEncode(8'h6B, 13'h1A65, "R3");

    // R1, R2, R3: every byte
    for (int d = 0; d < 256; d++) begin
      doEncode(8'(d), refEncode(8'(d)), "R1");
      for (int c = 0; c < 4; c++) begin
        n = 0;
        for (int p = 1; p < 13; p++) if (((p >> c) & 1) == 1 && encWord[p]) n++;
        checkEq("R2", "group parity odd", 32'(n % 2), 32'd1);
      end
      checkEq("R3", "word parity odd", 32'($countones(encWord) % 2), 32'd1);
    end

    // R4: hold when idle
    doEncode(8'h5A, refEncode(8'h5A), "R4");
    encData = 8'hFF;
    @(negedge clk);
    checkEq("R4", "encOutValid idle", 32'(encOutValid), 32'd0);
    checkEq("R4", "encWord held", 32'(encWord), 32'(refEncode(8'h5A)));

    // R5..R8: decode sweep
    for (int d = 0; d < 256; d++) begin
      w = refEncode(8'(d));
      doDecode(w, 8'(d), 2'd0, "R5");
      doDecode(w ^ 13'd1, 8'(d), 2'd1, "R7");
      for (int p = 1; p < 13; p++) doDecode(w ^ (13'd1 << p), 8'(d), 2'd1, "R6");
      for (int p = 0; p < 13; p++) begin
        for (int q = p + 1; q < 13; q++) begin
          bad = w ^ (13'd1 << p) ^ (13'd1 << q);
          doDecode(bad, refExtract(bad), 2'd2, "R8");
        end
      end
    end

    // R9: syndromes 13, 14, 15 with wrong overall parity
    for (int d = 0; d < 256; d += 17) begin
      w = refEncode(8'(d));
      bad = w ^ 13'h0112;
      doDecode(bad, refExtract(bad), 2'd2, "R9");
      bad = w ^ 13'h0114;
      doDecode(bad, refExtract(bad), 2'd2, "R9");
      bad = w ^ 13'h1006;
      doDecode(bad, refExtract(bad), 2'd2, "R9");
    end

    // R10: hold when idle
    w = refEncode(8'hC3);
    doDecode(w ^ 13'h0020, 8'hC3, 2'd1, "R10");
    decWord = 13'h0003;
    @(negedge clk);
    checkEq("R10", "decOutValid idle", 32'(decOutValid), 32'd0);
    checkEq("R10", "decData held", 32'(decData), 32'h0C3);
    checkEq("R10", "decStatus held", 32'(decStatus), 32'd1);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
    $finish;
  end

endmodule